// File: doc/BRIEF.md
# Receive-Line Active-Edge Interrupt Detector

This block sits beside a UART receiver. It watches the raw, asynchronous receive input and latches a sticky status bit the first time an active edge shows up on the line. Software selects which direction counts as active: a high-to-low transition or a low-to-high one. The raw input first passes through a multi-stage synchronizer. An edge is accepted only after the synchronized line has been seen resting at its deasserted level, so a line that is already active never produces a false event.

The latched bit drives an interrupt request through a local enable. The same gated request also serves as a wake request that brings a processor out of a wait state. Detection runs only while the port is in two-wire operation. In single-wire operation the bit never sets.

Software clears the bit with a one-cycle write-one-to-clear pulse. The reset is asynchronous and active-low, and it is expected to be released synchronously to the clock.

Top module: `rxline_edge_irq`

## Requirements
- R1: While reset is asserted, and on the first clocks after it is released, `edge_flag_o`, `irq_o` and `wake_o` are all 0.
- R2: With `pol_rise_i` = 0, a high-to-low change on `rx_async_i` sets `edge_flag_o`. The flag is 0 after the second rising clock edge that follows the input change and 1 after the third.
- R3: With `pol_rise_i` = 1, a low-to-high change on `rx_async_i` sets `edge_flag_o`, with the same latency as in R2.
- R4: A transition in the direction opposite to the one `pol_rise_i` selects never sets `edge_flag_o`.
- R5: While `two_wire_i` = 0, no transition of the line sets `edge_flag_o`. Once `two_wire_i` returns to 1, detection works again.
- R6: `edge_flag_o` stays 1 until a cycle in which `flag_clr_i` = 1 and no new edge is accepted. It is 0 after that clock edge.
- R7: When a new edge is accepted in the same cycle that `flag_clr_i` = 1, `edge_flag_o` remains 1.
- R8: `irq_o` is 1 exactly when `edge_flag_o` = 1 and `irq_en_i` = 1. `wake_o` follows `irq_o`.
- R9: A change of `pol_rise_i` never sets the flag by itself. After any polarity change, the line must again be seen at the new deasserted level before an edge counts.
- R10: After reset, a line that is held at its active level sets no flag. An edge counts only once the synchronizer holds real line samples and the deasserted level has been observed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_async_i | input | 1 | Raw receive line, asynchronous to `clk` |
| pol_rise_i | input | 1 | Active edge select: 0 = falling, 1 = rising |
| two_wire_i | input | 1 | 1 = two-wire operation (detection on), 0 = single-wire (detection off) |
| irq_en_i | input | 1 | Local interrupt enable |
| flag_clr_i | input | 1 | Write-one-to-clear pulse for the status bit |
| edge_flag_o | output | 1 | Sticky active-edge status bit |
| irq_o | output | 1 | Gated interrupt request |
| wake_o | output | 1 | Wake request from the wait state |

## Verification
A corrupted qualification bit shows at the ports as an extra flag. This happens after reset or after a polarity switch, within about four clocks of the first line transition. It can also show as a flag that never sets. A synchronizer or history stage that is off by one moves the moment the flag rises, so the bench pins the latency to the exact clock edge. The flag and gating logic are observed every cycle. A stuck flag register, or a clear that beats a simultaneous set, shows at the next edge.

// File: rtl/rxe_pkg.sv
package rxe_pkg;

  // Active-edge direction, taken from the polarity control input.
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_pol_e;

  // Current and one-cycle-old synchronized line samples.
  typedef struct packed {
    logic cur;
    logic prv;
  } lvl_pair_t;

  // Mark (idle) level of an asynchronous serial line.
  localparam logic LINE_MARK = 1'b1;

endpackage

// File: rtl/rxe_sync.sv
module rxe_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] stg_q;
  logic [LAST:0] stg_nxt;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign stg_nxt[g] = d_i;
      end else begin : g_rest
        assign stg_nxt[g] = stg_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_LVL}};
    end else begin
      stg_q <= stg_nxt;
    end
  end

  assign q_o = stg_q[LAST];

endmodule

// File: rtl/rxe_qual.sv
module rxe_qual
  import rxe_pkg::*;
#(
  parameter int FILL_W = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl_i,
  input  edge_pol_e pol_i,
  input  logic      two_wire_i,
  output logic      edge_o
);

  localparam int FILL_TOP = FILL_W - 1;

  // History stage, fill tracker, last polarity, qualification
  logic              lvl_d_q;
  logic [FILL_TOP:0] fill_q, fill_nxt;
  edge_pol_e         pol_q;
  logic              qual_q, qual_nxt;

  lvl_pair_t pair;
  logic      act_cur, act_prv;
  logic      pol_chg;
  logic      live;

  assign pair.cur = lvl_i;
  assign pair.prv = lvl_d_q;

  // A sample is "active" when it equals the asserted level for the polarity.
  always_comb begin
    act_cur  = (pair.cur == logic'(pol_i));
    act_prv  = (pair.prv == logic'(pol_i));
    pol_chg  = (pol_i != pol_q);
    live     = two_wire_i && fill_q[FILL_TOP] && !pol_chg;
    fill_nxt = {fill_q[FILL_TOP-1:0], 1'b1};
    if (live) begin
      qual_nxt = qual_q || (!act_cur && !act_prv);
    end else begin
      qual_nxt = 1'b0;
    end
    edge_o = live && qual_q && act_cur && !act_prv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d_q <= LINE_MARK;
      fill_q  <= '0;
      pol_q   <= EDGE_FALL;
      qual_q  <= 1'b0;
    end else begin
      lvl_d_q <= pair.cur;
      fill_q  <= fill_nxt;
      pol_q   <= pol_i;
      qual_q  <= qual_nxt;
    end
  end

endmodule

// File: rtl/rxe_flag.sv
module rxe_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o,
  output logic wake_o
);

  logic flag_q, flag_nxt, flag_upd;

  // A set beats a clear arriving in the same cycle.
  always_comb begin
    flag_upd = set_i || clr_i;
    if (set_i) begin
      flag_nxt = 1'b1;
    end else begin
      flag_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_upd) begin
      flag_q <= flag_nxt;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && en_i;
  assign wake_o = irq_o;

endmodule

// File: rtl/rxline_edge_irq.sv
module rxline_edge_irq
  import rxe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_async_i,
  input  logic pol_rise_i,
  input  logic two_wire_i,
  input  logic irq_en_i,
  input  logic flag_clr_i,
  output logic edge_flag_o,
  output logic irq_o,
  output logic wake_o
);

  // History stage follows the synchronizer: its depth plus one cycle
  localparam int FILL_W = SYNC_STAGES + 1;

  logic      rx_sync;
  logic      edge_hit;
  edge_pol_e pol_sel;

  assign pol_sel = edge_pol_e'(pol_rise_i);

  rxe_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_LVL (LINE_MARK)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rx_async_i),
    .q_o   (rx_sync)
  );

  rxe_qual #(
    .FILL_W (FILL_W)
  ) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_i      (rx_sync),
    .pol_i      (pol_sel),
    .two_wire_i (two_wire_i),
    .edge_o     (edge_hit)
  );

  rxe_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (edge_hit),
    .clr_i  (flag_clr_i),
    .en_i   (irq_en_i),
    .flag_o (edge_flag_o),
    .irq_o  (irq_o),
    .wake_o (wake_o)
  );

endmodule

// File: rtl/rxe_chk.sv
module rxe_chk (
  input logic clk,
  input logic rst_n,
  input logic pol_rise_i,
  input logic two_wire_i,
  input logic irq_en_i,
  input logic flag_clr_i,
  input logic edge_flag_o,
  input logic irq_o,
  input logic wake_o
);

  AST_SINGLE_WIRE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!two_wire_i && !edge_flag_o) |=> !edge_flag_o); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_flag_o && !flag_clr_i) |=> edge_flag_o); // R6

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (edge_flag_o && irq_en_i)); // R8

  AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_flag_o |-> !wake_o); // R8

  AST_POL_SWITCH_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_flag_o && (pol_rise_i != $past(pol_rise_i))) |=> !edge_flag_o); // R9

endmodule

bind rxline_edge_irq rxe_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pol_rise_i  (pol_rise_i),
  .two_wire_i  (two_wire_i),
  .irq_en_i    (irq_en_i),
  .flag_clr_i  (flag_clr_i),
  .edge_flag_o (edge_flag_o),
  .irq_o       (irq_o),
  .wake_o      (wake_o)
);

// File: tb/sim_rxline_edge_irq.sv
`timescale 1ns/100ps
module sim_rxline_edge_irq;

  logic clk = 1'b0;
  logic rst_n, rx, pol, tw, en, clr;
  logic flag, irq, wake;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    string tag;
    logic  f;
    logic  i;
    logic  w;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  rxline_edge_irq u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_async_i  (rx),
    .pol_rise_i  (pol),
    .two_wire_i  (tw),
    .irq_en_i    (en),
    .flag_clr_i  (clr),
    .edge_flag_o (flag),
    .irq_o       (irq),
    .wake_o      (wake)
  );

  // Driver side: expectation for the outputs after the next rising edge
  task automatic expect_out(string tag, logic f, logic i, logic w);
    exp_t e;
    e.tag = tag; e.f = f; e.i = i; e.w = w;
    sb.push_back(e);
  endtask

  task automatic nclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flag();
    clr = 1'b1;
    nclk(1);
    clr = 1'b0;
  endtask

  // Monitor: pops one expectation per clock, samples 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if ({flag, irq, wake} !== {e.f, e.i, e.w}) begin
          n_fail++;
          $display("FAIL %s: flag/irq/wake = %b%b%b, expected %b%b%b",
                   e.tag, flag, irq, wake, e.f, e.i, e.w);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx = 1'b1; pol = 1'b0; tw = 1'b1; en = 1'b1; clr = 1'b0;
    nclk(2);
    expect_out("R1", 0, 0, 0);
    nclk(1);
    rst_n = 1'b1;
    expect_out("R1", 0, 0, 0);
    nclk(6);

    // R2: falling edge, exact latency
    rx = 1'b0;
    nclk(1); expect_out("R2", 0, 0, 0);
    nclk(1); expect_out("R2", 1, 1, 1);
    nclk(1);

    // R6: sticky, then cleared
    rx = 1'b1;
    nclk(5); expect_out("R6", 1, 1, 1);
    nclk(1); clr = 1'b1; expect_out("R6", 0, 0, 0);
    nclk(1); clr = 1'b0; expect_out("R6", 0, 0, 0);
    nclk(1);

    // R4: rising edge ignored in falling mode
    rx = 1'b0;
    nclk(4); expect_out("R2", 1, 1, 1);
    nclk(1); clear_flag();
    rx = 1'b1;
    nclk(4); expect_out("R4", 0, 0, 0);
    nclk(1);

    // R8: enable gating
    en = 1'b0; rx = 1'b0;
    nclk(4); expect_out("R8", 1, 0, 0);
    nclk(1); en = 1'b1; expect_out("R8", 1, 1, 1);
    nclk(1); clear_flag();

    // R7: set wins over clear in the same cycle
    rx = 1'b1;
    nclk(4); rx = 1'b0;
    nclk(2); clr = 1'b1; expect_out("R7", 1, 1, 1);
    nclk(1); clr = 1'b0; expect_out("R7", 1, 1, 1);
    nclk(1); clear_flag(); expect_out("R6", 0, 0, 0);
    nclk(1);

    // R3 and R9: switch to rising mode with the line low
    pol = 1'b1;
    nclk(6); expect_out("R9", 0, 0, 0);
    nclk(1); rx = 1'b1;
    nclk(1); expect_out("R3", 0, 0, 0);
    nclk(1); expect_out("R3", 1, 1, 1);
    nclk(1); clear_flag();
    rx = 1'b0;
    nclk(4); expect_out("R4", 0, 0, 0);
    nclk(1);

    // R9: back to falling mode with the line held at the active level
    pol = 1'b0;
    nclk(6); expect_out("R9", 0, 0, 0);
    nclk(1); rx = 1'b1;
    nclk(4); rx = 1'b0;
    nclk(1); expect_out("R9", 0, 0, 0);
    nclk(1); expect_out("R2", 1, 1, 1);
    nclk(1); clear_flag();

    // R5: single-wire mode suppresses detection
    tw = 1'b0;
    rx = 1'b1; nclk(4);
    rx = 1'b0; nclk(4);
    rx = 1'b1; nclk(4);
    rx = 1'b0; nclk(4);
    expect_out("R5", 0, 0, 0);
    nclk(1); tw = 1'b1; rx = 1'b1;
    nclk(4); rx = 1'b0;
    nclk(2); expect_out("R5", 1, 1, 1);
    nclk(1);

    // R10: reset with the line at the active level
    rst_n = 1'b0; rx = 1'b0; pol = 1'b0;
    nclk(1); expect_out("R1", 0, 0, 0);
    nclk(1); rst_n = 1'b1;
    nclk(8); expect_out("R10", 0, 0, 0);
    nclk(1); rx = 1'b1;
    nclk(4); rx = 1'b0;
    nclk(2); expect_out("R10", 1, 1, 1);
    nclk(1);

    wait (sb.size() == 0);
    nclk(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule